// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Zero-Turnaround Bus

This block is a cycle-accurate, synthesizable model of a synchronous static RAM whose bus can swap between reads and writes on every clock with no idle slot. Address and control are taken at a rising edge. Write data follows that edge later, on the same data slot where a read's result would appear. A static mode input selects the timing. In the registered-read mode, read data leaves an output register one edge after the access and write data trails the address by two edges. In the combinational-read mode, read data appears during the access cycle itself and write data trails the address by one edge.

Each word is split into 9-bit byte lanes. Each lane has an active-low write enable. A four-beat burst is stepped by an advance input. Its beat order is either a wrapping increment of the two low address bits or an XOR of those bits with the beat index. Writes are still in flight when later reads arrive. For that reason, a forwarding path merges any pending lane data into read results, so the data bus always sees program-order contents. An asynchronous output enable and a sleep input gate the read driver.

Because the model has no tristate, a bus that is not driven is shown as `dout_oe` low with `dout` held at zero.

Top module: `lw_sync_sram`

## Requirements
- R1: Inputs are taken only at the rising clock edge. A new cycle starts only when `sel0_n`=0, `sel1`=1, `sel2_n`=0, `adv`=0 and `sleep`=0. In that cycle `we_n`=0 means a write and `we_n`=1 means a read. Any other combination with `adv`=0 is a deselect.
- R2: With `flow_mode`=0, a read taken at edge N drives its word on `dout` with `dout_oe`=1 from edge N+1 until edge N+2.
- R3: With `flow_mode`=1, a read taken at edge N drives its word from edge N until edge N+1.
- R4: Write data for a write taken at edge N is taken from `din` at edge N+2 when `flow_mode`=0, and at edge N+1 when `flow_mode`=1. Byte enables are taken with the address. Lane i is `din[9i+8:9i]` and is written only when `bw_n[i]`=0.
- R5: Reads and writes may follow each other on every edge. A read always returns the latest data written in program order, including lanes of writes whose data has not reached the array yet.
- R6: The data slot of a deselect, a write, or a cycle with no accepted operation has `dout_oe`=0 and `dout`=0.
- R7: When `adv`=1 at an edge and a burst is running, the next beat is issued with the burst's read/write type. Its address keeps the upper bits of the start address. Its low 2 bits are (start+k) mod 4 when `ilv_order`=0, or start XOR k when `ilv_order`=1, for beat k=1,2,3,0,... When `adv`=1 and no burst is running, the cycle is a deselect. The chip selects and `we_n` are ignored whenever `adv`=1.
- R8: `oe_n`=1 forces `dout_oe`=0 and `dout`=0 at once, without waiting for a clock edge. Clearing `oe_n` restores a pending read word.
- R9: An edge with `sleep`=1 accepts no cycle and ends any burst. `dout_oe` is 0 while `sleep`=1. A write already accepted still completes.
- R10: Synchronous active-high `rst` empties the pipeline, so `dout_oe` is 0 during and after reset until a new read is due. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| addr | input | AW | Word address |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write, 1 = read |
| adv | input | 1 | Step the running burst |
| bw_n | input | NB | Per-lane write enables, active low |
| din | input | NB*BW | Late write data |
| flow_mode | input | 1 | 1 = combinational read, single late write; 0 = registered read, double late write |
| ilv_order | input | 1 | 0 = wrapping increment order, 1 = XOR order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request |
| dout | output | NB*BW | Read data, zero when not driven |
| dout_oe | output | 1 | Read driver active |

## Verification
Each operation is placed at the edge N where it is accepted. In combinational-read mode its read word is due in the half cycle right after edge N; in registered-read mode it is due one edge later. Write data is owed at edge N+1 or N+2 according to the same mode. The bench keeps a 16-slot ring indexed by edge count. At each accepted operation it books the expected read word in the slot of the edge where that word becomes visible, and it books the write data in the slot of the edge where `din` will be taken. It samples at the falling edge after every rising edge and compares with the booked slot. Expected words come from a program-order reference memory updated at the moment each write is accepted, so forwarding is checked by plain sequential semantics.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  // Burst beat ordering selected by the order input
  typedef enum logic {
    ORD_WRAP_INC = 1'b0,
    ORD_XOR      = 1'b1
  } order_e;

  // Low two address bits for beat k of a burst that started at 'start'
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] k,
                                         input order_e     ord);
    logic [1:0] r;
    if (ord == ORD_XOR) r = start ^ k;
    else                r = start + k;
    return r;
  endfunction

endpackage

// File: rtl/lwsram_burst.sv
module lwsram_burst #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          adv,
  input  logic          sel_all,
  input  logic          wr_req,
  input  logic [AW-1:0] addr_in,
  input  logic          ilv_order,
  output logic          iss_v,
  output logic          iss_wr,
  output logic [AW-1:0] iss_addr
);
  import lwsram_pkg::*;

  logic          act;
  logic          wr_q;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic          cont;
  logic          fresh;
  logic [1:0]    nxt_lo;
  order_e        ord;

  assign ord = order_e'(ilv_order);

  always_comb begin
    cont   = adv && act && !sleep;
    fresh  = !sleep && !adv && sel_all;
    nxt_lo = beat_lo(base[1:0], cnt + 2'd1, ord);
    iss_v  = cont || fresh;
    iss_wr = cont ? wr_q : wr_req;
    iss_addr = cont ? {base[AW-1:2], nxt_lo} : addr_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      cnt  <= 2'd0;
      wr_q <= 1'b0;
      base <= '0;
    end else if (cont) begin
      cnt <= cnt + 2'd1;
    end else if (fresh) begin
      act  <= 1'b1;
      cnt  <= 2'd0;
      base <= addr_in;
      wr_q <= wr_req;
    end else begin
      act <= 1'b0;
    end
  end

  // R7: each advance steps the beat count by one
  assert_advance_step_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && act && !sleep) |=> (cnt == $past(cnt) + 2'd1));

  // R1: a fresh selected cycle opens a burst at beat zero
  assert_fresh_restart_R1: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !adv && sel_all) |=> (act && cnt == 2'd0));

  // R9: sleep ends the burst
  assert_sleep_ends_burst_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !act);

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB-1:0]    wbe,
  input  logic [NB*BW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  // One read-first RAM per lane so that lane writes map onto block RAM
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] mem [DEPTH];
    logic [BW-1:0] rq;
    always_ff @(posedge clk) begin
      if (we && wbe[g]) mem[waddr] <= wdata[g*BW +: BW];
      rq <= mem[raddr];
    end
    assign rdata[g*BW +: BW] = rq;
  end

endmodule

// File: rtl/lwsram_merge.sv
module lwsram_merge #(
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic [NB*BW-1:0] old_w,
  input  logic [NB*BW-1:0] new_w,
  input  logic [NB-1:0]    lane_en,
  input  logic             hit,
  output logic [NB*BW-1:0] res
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign res[g*BW +: BW] = (hit && lane_en[g]) ? new_w[g*BW +: BW]
                                                 : old_w[g*BW +: BW];
  end
endmodule

// File: rtl/lw_sync_sram.sv
module lw_sync_sram #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             we_n,
  input  logic             adv,
  input  logic [NB-1:0]    bw_n,
  input  logic [NB*BW-1:0] din,
  input  logic             flow_mode,
  input  logic             ilv_order,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [NB*BW-1:0] dout,
  output logic             dout_oe
);
  localparam int DW = NB * BW;

  logic          sel_all;
  logic          iss_v, iss_wr;
  logic [AW-1:0] iss_addr;

  // Access stage (s1) and late-write stage (s2)
  logic          s1_v, s1_wr, s2_v, s2_wr;
  logic [AW-1:0] s1_a, s2_a;
  logic [NB-1:0] s1_be, s2_be;

  // Write commit this edge, and the commit of the previous edge
  logic          cw_v;
  logic [AW-1:0] cw_a;
  logic [NB-1:0] cw_be;
  logic          cm_v;
  logic [AW-1:0] cm_a;
  logic [NB-1:0] cm_be;
  logic [DW-1:0] cm_d;

  logic [DW-1:0] rd_q, m1, m2, pq_d;
  logic          pq_v;
  logic          hit1, hit2;
  logic          out_v;
  logic [DW-1:0] out_d;

  assign sel_all = !sel0_n && sel1 && !sel2_n;

  lwsram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst(rst), .sleep(sleep), .adv(adv), .sel_all(sel_all),
    .wr_req(!we_n), .addr_in(addr), .ilv_order(ilv_order),
    .iss_v(iss_v), .iss_wr(iss_wr), .iss_addr(iss_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= iss_v;
      s2_v <= s1_v;
    end
    s1_wr <= iss_wr;
    s1_a  <= iss_addr;
    s1_be <= ~bw_n;
    s2_wr <= s1_wr;
    s2_a  <= s1_a;
    s2_be <= s1_be;
  end

  // Mode picks which stage owns the data slot at this edge
  always_comb begin
    if (flow_mode) begin
      cw_v  = s1_v && s1_wr;
      cw_a  = s1_a;
      cw_be = s1_be;
    end else begin
      cw_v  = s2_v && s2_wr;
      cw_a  = s2_a;
      cw_be = s2_be;
    end
  end

  lwsram_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk(clk), .we(cw_v), .waddr(cw_a), .wbe(cw_be), .wdata(din),
    .raddr(iss_addr), .rdata(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) cm_v <= 1'b0;
    else     cm_v <= cw_v;
    cm_a  <= cw_a;
    cm_be <= cw_be;
    cm_d  <= din;
  end

  // Forwarding: older pending write first, then the one landing now
  assign hit1 = cm_v && (cm_a == s1_a);
  assign hit2 = cw_v && (cw_a == s1_a);

  lwsram_merge #(.NB(NB), .BW(BW)) u_fwd_old (
    .old_w(rd_q), .new_w(cm_d), .lane_en(cm_be), .hit(hit1), .res(m1)
  );

  lwsram_merge #(.NB(NB), .BW(BW)) u_fwd_new (
    .old_w(m1), .new_w(din), .lane_en(cw_be), .hit(hit2), .res(m2)
  );

  always_ff @(posedge clk) begin
    if (rst) pq_v <= 1'b0;
    else     pq_v <= s1_v && !s1_wr;
    pq_d <= m2;
  end

  assign out_v   = flow_mode ? (s1_v && !s1_wr) : pq_v;
  assign out_d   = flow_mode ? m1 : pq_d;
  assign dout_oe = out_v && !oe_n && !sleep;
  assign dout    = dout_oe ? out_d : '0;

  // R6: no read at the access stage means a silent registered data slot
  assert_deselect_slot_R6: assert property (@(posedge clk) disable iff (rst)
    (!flow_mode && !(s1_v && !s1_wr)) |=> !dout_oe);

  // R4: double late write commits a write accepted two edges back
  assert_double_late_R4: assert property (@(posedge clk) disable iff (rst)
    (!flow_mode && cw_v) |-> $past(s1_v && s1_wr));

  // R4: single late write commits a write accepted one edge back
  assert_single_late_R4: assert property (@(posedge clk) disable iff (rst)
    (flow_mode && cw_v) |-> $past(iss_v && iss_wr));

  // R9: no cycle enters the access stage from a sleeping edge
  assert_sleep_no_issue_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !s1_v);

endmodule

// File: tb/lw_sync_sram_tb.sv
module lw_sync_sram_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          sel0_n, sel1, sel2_n, we_n, adv;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] din;
  logic          flow_mode, ilv_order, oe_n, sleep;
  logic [DW-1:0] dout;
  logic          dout_oe;

  lw_sync_sram #(.AW(AW), .NB(NB), .BW(BW)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .we_n(we_n), .adv(adv), .bw_n(bw_n), .din(din),
    .flow_mode(flow_mode), .ilv_order(ilv_order), .oe_n(oe_n),
    .sleep(sleep), .dout(dout), .dout_oe(dout_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [DW-1:0] refm [DEPTH];
  bit            exp_v [16];
  logic [DW-1:0] exp_d [16];
  string         exp_tag [16];
  bit            din_v [16];
  logic [DW-1:0] din_s [16];
  int            cyc = 0;
  int            desel_rot = 0;
  bit            b_act = 0, b_wr = 0;
  logic [AW-1:0] b_base = '0;
  int            b_cnt = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int k, input bit ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ 2'(k)) : 2'(b[1:0] + 2'(k));
    return {b[AW-1:2], lo};
  endfunction

  // kind: 0 deselect, 1 read, 2 write, 3 advance
  task automatic tick(input int kind, input logic [AW-1:0] a, input logic [NB-1:0] bwn,
                      input logic [DW-1:0] wd, input bit slp, input bit oen, input string tag);
    int e, lat, s, t;
    bit eo, op_v, op_w;
    logic [AW-1:0] oa;
    e = cyc + 1;
    lat = flow_mode ? 1 : 2;
    s = cyc % 16;
    eo = exp_v[s] && !oe_n && !sleep;
    chk({exp_tag[s], " driver enable"}, DW'(dout_oe), DW'(eo));
    if (eo) chk({exp_tag[s], " read word"}, dout, exp_d[s]);
    else    chk({exp_tag[s], " R6 undriven bus zero"}, dout, '0);
    exp_v[s] = 0;
    exp_tag[s] = "R6";
    op_v = 0; op_w = 0; oa = a;
    if (slp) b_act = 0;
    else if (kind == 3) begin
      if (b_act) begin
        b_cnt++;
        oa = beat_addr(b_base, b_cnt, ilv_order);
        op_v = 1; op_w = b_wr;
      end
    end else if (kind == 1 || kind == 2) begin
      b_act = 1; b_base = a; b_cnt = 0; b_wr = (kind == 2);
      op_v = 1; op_w = b_wr;
    end else b_act = 0;
    t = (e + lat - 1) % 16;
    exp_tag[t] = tag;
    if (op_v && op_w) begin
      for (int l = 0; l < NB; l++)
        if (!bwn[l]) refm[oa][l*BW +: BW] = wd[l*BW +: BW];
      din_s[(e + lat) % 16] = wd;
      din_v[(e + lat) % 16] = 1;
    end
    if (op_v && !op_w) begin
      exp_v[t] = 1;
      exp_d[t] = refm[oa];
    end
    adv = (kind == 3);
    addr = (kind == 3) ? AW'($urandom) : a;
    we_n = (kind == 3) ? 1'($urandom) : !(kind == 2);
    sel0_n = 0; sel1 = 1; sel2_n = 0;
    if (kind == 3 && $urandom % 2 == 0) sel1 = 0;
    if (kind == 0) begin
      case (desel_rot)
        0: sel0_n = 1;
        1: sel1 = 0;
        default: sel2_n = 1;
      endcase
      desel_rot = (desel_rot + 1) % 3;
    end
    bw_n = bwn;
    sleep = slp;
    oe_n = oen;
    din = din_v[e % 16] ? din_s[e % 16] : {$urandom, $urandom};
    din_v[e % 16] = 0;
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, '0, '1, '0, 0, 0, tag);
  endtask

  task automatic do_reset(input bit mode);
    idle(4, "R6");
    rst = 1;
    flow_mode = mode;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 driver off in reset", DW'(dout_oe), '0);
    rst = 0;
    b_act = 0;
    for (int i = 0; i < 16; i++) begin exp_v[i] = 0; din_v[i] = 0; exp_tag[i] = "R10"; end
  endtask

  task automatic directed(input string rdtag);
    logic [DW-1:0] d1, d2;
    d1 = {$urandom, $urandom};
    d2 = {$urandom, $urandom};
    // R5: two partial writes then immediate reads of the same word
    tick(2, 6'h05, 4'b1100, d1, 0, 0, "R4");
    tick(2, 6'h05, 4'b0011, d2, 0, 0, "R4");
    tick(1, 6'h05, '1, '0, 0, 0, "R5 forward");
    tick(2, 6'h05, 4'b0111, d1, 0, 0, "R5");
    tick(1, 6'h05, '1, '0, 0, 0, "R5 forward");
    tick(1, 6'h05, '1, '0, 0, 0, rdtag);
    // R1: each chip select alone deselects
    idle(3, "R1 deselect");
    // R7: bursts in both orders, reads then writes
    for (int o = 0; o < 2; o++) begin
      ilv_order = o[0];
      tick(1, 6'h0A, '1, '0, 0, 0, "R7 burst read");
      for (int k = 0; k < 5; k++) tick(3, '0, '1, '0, 0, 0, "R7 burst read");
      tick(2, 6'h13, '0, {$urandom, $urandom}, 0, 0, "R7 burst write");
      for (int k = 0; k < 3; k++) tick(3, '0, 4'(k), {$urandom, $urandom}, 0, 0, "R7 burst write");
      for (int k = 0; k < 4; k++) tick(1, 6'h10 + 6'(k), '1, '0, 0, 0, "R7 readback");
    end
    ilv_order = 0;
    // R7: advance with no running burst is a deselect
    idle(1, "R6");
    tick(3, '0, '1, '0, 0, 0, "R7 advance without burst");
    tick(3, '0, '1, '0, 0, 0, "R7 advance without burst");
    // R9: write in flight across sleep, read blocked by sleep
    tick(2, 6'h21, '0, d2, 0, 0, "R9");
    tick(1, 6'h21, '1, '0, 1, 0, "R9 sleep blocks read");
    tick(1, 6'h22, '1, '0, 1, 0, "R9 sleep blocks read");
    tick(0, '0, '1, '0, 0, 0, "R9");
    tick(1, 6'h21, '1, '0, 0, 0, "R9 write survived sleep");
    tick(1, 6'h22, '1, '0, 0, 0, "R9 read into sleep slot");
    tick(0, '0, '1, '0, 1, 0, "R9");
    idle(2, "R6");
    // R8: asynchronous output enable in the middle of a read slot
    tick(1, 6'h05, '1, '0, 0, 0, rdtag);
    if (!flow_mode) idle(1, "R6");
    oe_n = 1;
    #1;
    chk("R8 async enable off", DW'(dout_oe), '0);
    chk("R8 async bus zero", dout, '0);
    oe_n = 0;
    #1;
    chk("R8 async enable back", DW'(dout_oe), DW'(1));
    idle(3, "R6");
  endtask

  task automatic random_run(input int n, input string rdtag);
    int r;
    logic [AW-1:0] a;
    for (int i = 0; i < n; i++) begin
      r = $urandom % 100;
      a = ($urandom % 2) ? AW'($urandom % 8) : AW'($urandom);
      if (i % 200 == 0) ilv_order = 1'($urandom);
      if (r < 8)       tick(0, a, '1, '0, 0, ($urandom % 10) == 0, "R1");
      else if (r < 35) tick(1, a, 4'($urandom), '0, 0, ($urandom % 10) == 0, rdtag);
      else if (r < 60) tick(2, a, 4'($urandom), {$urandom, $urandom}, 0, ($urandom % 10) == 0, "R5");
      else if (r < 92) tick(3, a, 4'($urandom), {$urandom, $urandom}, 0, ($urandom % 10) == 0, "R7");
      else             tick(1, a, '1, '0, 1, 0, "R9");
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20417));
    rst = 1; addr = '0; sel0_n = 1; sel1 = 0; sel2_n = 1; we_n = 1; adv = 0;
    bw_n = '1; din = '0; flow_mode = 1; ilv_order = 0; oe_n = 0; sleep = 0;
    for (int i = 0; i < 16; i++) begin exp_v[i] = 0; din_v[i] = 0; exp_tag[i] = "R10"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 driver off in reset", DW'(dout_oe), '0);
    rst = 0;
    // Fill the array so every read has a known value (R4 single late write)
    for (int i = 0; i < DEPTH; i++) tick(2, AW'(i), '0, {$urandom, $urandom}, 0, 0, "R4");
    idle(2, "R10");
    directed("R3 flow read");
    random_run(900, "R3 flow read");
    do_reset(0);
    directed("R2 registered read");
    random_run(900, "R2 registered read");
    idle(4, "R6");
    finish_up();
  end

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

endmodule